// File: doc/BRIEF.md
# String and Loop Repeat Controller

This block sequences repeated string element transfers and counted loop steps. It owns a 16-bit count register and two 16-bit pointers: a source pointer that pairs with the data segment and a destination pointer that pairs with the extra segment. A string command runs one element at a time. For each element it presents both pointers on a request handshake and waits for the memory side to acknowledge. Only then does it move both pointers and decrement the count. The step is one for byte elements and two for word elements. The pointers count up when the direction input is 0 and down when it is 1.

Two branch primitives also work on the count. The first is a decrement-then-test step: it lowers the count and reports a taken branch while the new count is nonzero, so entering it with a zero count wraps to FFFFh and gives 65,536 passes. The second is a zero test that leaves the count untouched. Two of the repeat variants also watch a zero-flag value returned with each acknowledge and end early when the compare condition fails. Physical address formation, instruction decode and flag storage sit outside this block, so no command here ever alters a flag.

Top module: `strloop_ctrl`

## Requirements
- R1: After reset the count, source and destination pointers read 0, and `mem_req`, `busy`, `done` and `br_valid` are low.
- R2: A load (`ld_en` high while idle) writes `ld_cnt`, `ld_src` and `ld_dst` into the count and the pointers, which are visible on the outputs in the next cycle. A load has priority over a command in the same cycle.
- R3: During an element, `mem_req` stays high with `mem_src` and `mem_dst` held steady until `mem_ack`. After the acknowledge both pointers change by the same step: +1 or +2 when the direction is 0, and -1 or -2 when it is 1 (2 when `cmd_wide` is 1). The result wraps modulo 2^16.
- R4: Command code 0 (unconditional repeat) with a nonzero count N performs exactly N elements and ends with the count at 0. The count drops by one at each acknowledge. `done` is a one-cycle pulse in the cycle after the final acknowledge, and it is never high together with `mem_req`.
- R5: A repeat command (codes 0, 1, 2) issued with a count of 0 makes no request and raises `done` in the cycle after the command.
- R6: Code 1 (repeat while equal) also ends after an element whose acknowledge carries `mem_zf`=0. Code 2 (repeat while not equal) ends after an element whose acknowledge carries `mem_zf`=1. That last element still updates the count and the pointers.
- R7: Code 3 (loop step) sets the count to count-1 and raises `br_valid` in the next cycle, with `br_taken` high exactly when the new count is nonzero. It leaves the pointers unchanged. A count of 0 becomes FFFFh with the branch taken, giving 65,536 passes in total.
- R8: Code 4 (zero test) raises `br_valid` in the next cycle with `br_taken` high exactly when the count is 0, and it leaves the count unchanged.
- R9: While `busy` is high, loads and commands are ignored. The count changes only on an acknowledge, and `br_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load count and pointers (idle only) |
| ld_cnt | input | 16 | Count value to load |
| ld_src | input | 16 | Source pointer value to load |
| ld_dst | input | 16 | Destination pointer value to load |
| cmd_valid | input | 1 | Command strobe (idle only) |
| cmd_op | input | 3 | 0 repeat, 1 repeat while equal, 2 repeat while not equal, 3 loop step, 4 zero test |
| cmd_dir | input | 1 | Pointer direction: 0 up, 1 down |
| cmd_wide | input | 1 | Element size: 0 byte, 1 word |
| mem_req | output | 1 | Element transfer request |
| mem_src | output | 16 | Source pointer offset (data segment) |
| mem_dst | output | 16 | Destination pointer offset (extra segment) |
| mem_wide | output | 1 | Element size of the running repeat |
| mem_ack | input | 1 | Element transfer acknowledge |
| mem_zf | input | 1 | Zero-flag result of the element's compare, valid with `mem_ack` |
| busy | output | 1 | A repeat is in progress |
| done | output | 1 | One-cycle pulse at the end of a repeat |
| br_valid | output | 1 | Branch result valid |
| br_taken | output | 1 | Branch taken |
| cnt_out | output | 16 | Current count |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |

## Verification
A repeat's first request is due one cycle after the command edge. The pointer and count updates of an element are due one cycle after its acknowledge edge, and `done` appears in that same cycle for the last element, or one cycle after the command when the count starts at zero. Loop-step and zero-test results are due exactly one cycle after the command. The bench drives every input and samples every output on the falling clock edge, so each result is read at the first falling edge after the rising edge that produces it. A scoreboard queue holds the expected pointer pair and flag of every element, and the responder compares each request against it on every cycle, including stall cycles.

// File: rtl/strloop_pkg.sv
package strloop_pkg;
  localparam logic [2:0] OP_REP   = 3'd0;
  localparam logic [2:0] OP_REPE  = 3'd1;
  localparam logic [2:0] OP_REPNE = 3'd2;
  localparam logic [2:0] OP_LOOP  = 3'd3;
  localparam logic [2:0] OP_JCXZ  = 3'd4;

  localparam int NPTR    = 2;
  localparam int SRC_IDX = 0;
  localparam int DST_IDX = 1;

  typedef enum logic {ST_IDLE, ST_XFER} st_e;
endpackage

// File: rtl/strloop_ptr_step.sv
module strloop_ptr_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic         dir,
  input  logic         wide,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] STEP_B = W'(1);
  localparam logic [W-1:0] STEP_W = W'(2);

  logic [W-1:0] step;

  assign step = wide ? STEP_W : STEP_B;
  assign nxt  = dir ? (cur - step) : (cur + step);
endmodule

// File: rtl/strloop_cnt_eval.sv
module strloop_cnt_eval #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  output logic [W-1:0] dec,
  output logic         dec_zero,
  output logic         cur_zero
);
  assign dec      = cnt - W'(1);
  assign dec_zero = (dec == '0);
  assign cur_zero = (cnt == '0);
endmodule

// File: rtl/strloop_ctrl.sv
module strloop_ctrl
  import strloop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [W-1:0] ld_cnt,
  input  logic [W-1:0] ld_src,
  input  logic [W-1:0] ld_dst,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic         cmd_dir,
  input  logic         cmd_wide,
  output logic         mem_req,
  output logic [W-1:0] mem_src,
  output logic [W-1:0] mem_dst,
  output logic         mem_wide,
  input  logic         mem_ack,
  input  logic         mem_zf,
  output logic         busy,
  output logic         done,
  output logic         br_valid,
  output logic         br_taken,
  output logic [W-1:0] cnt_out,
  output logic [W-1:0] src_out,
  output logic [W-1:0] dst_out
);
  st_e                      st_q;
  logic [W-1:0]             cnt_q;
  logic [NPTR-1:0][W-1:0]   ptr_q;
  logic [NPTR-1:0][W-1:0]   ptr_nxt;
  logic                     dir_q;
  logic                     wide_q;
  logic [2:0]               kind_q;
  logic                     done_q;
  logic                     brv_q;
  logic                     brt_q;

  logic [W-1:0]             cnt_dec;
  logic                     dec_zero;
  logic                     cur_zero;
  logic                     cmp_stop;
  logic                     is_str_op;

  strloop_cnt_eval #(.W(W)) u_cnt (
    .cnt      (cnt_q),
    .dec      (cnt_dec),
    .dec_zero (dec_zero),
    .cur_zero (cur_zero)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    strloop_ptr_step #(.W(W)) u_step (
      .cur  (ptr_q[g]),
      .dir  (dir_q),
      .wide (wide_q),
      .nxt  (ptr_nxt[g])
    );
  end

  assign is_str_op = (cmd_op == OP_REP) || (cmd_op == OP_REPE) || (cmd_op == OP_REPNE);

  always_comb begin
    cmp_stop = 1'b0;
    if (kind_q == OP_REPE)  cmp_stop = !mem_zf;
    if (kind_q == OP_REPNE) cmp_stop = mem_zf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ptr_q  <= '0;
      dir_q  <= 1'b0;
      wide_q <= 1'b0;
      kind_q <= OP_REP;
      done_q <= 1'b0;
      brv_q  <= 1'b0;
      brt_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      brv_q  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (ld_en) begin
            cnt_q          <= ld_cnt;
            ptr_q[SRC_IDX] <= ld_src;
            ptr_q[DST_IDX] <= ld_dst;
          end else if (cmd_valid) begin
            if (is_str_op) begin
              dir_q  <= cmd_dir;
              wide_q <= cmd_wide;
              kind_q <= cmd_op;
              if (cur_zero) done_q <= 1'b1;
              else          st_q   <= ST_XFER;
            end else if (cmd_op == OP_LOOP) begin
              cnt_q <= cnt_dec;
              brv_q <= 1'b1;
              brt_q <= !dec_zero;
            end else if (cmd_op == OP_JCXZ) begin
              brv_q <= 1'b1;
              brt_q <= cur_zero;
            end
          end
        end
        ST_XFER: begin
          if (mem_ack) begin
            ptr_q <= ptr_nxt;
            cnt_q <= cnt_dec;
            if (dec_zero || cmp_stop) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req  = (st_q == ST_XFER);
  assign busy     = (st_q == ST_XFER);
  assign mem_src  = ptr_q[SRC_IDX];
  assign mem_dst  = ptr_q[DST_IDX];
  assign mem_wide = wide_q;
  assign done     = done_q;
  assign br_valid = brv_q;
  assign br_taken = brt_q;
  assign cnt_out  = cnt_q;
  assign src_out  = ptr_q[SRC_IDX];
  assign dst_out  = ptr_q[DST_IDX];
endmodule

// File: rtl/strloop_ctrl_chk.sv
module strloop_ctrl_chk
  import strloop_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         ld_en,
  input logic         cmd_valid,
  input logic [2:0]   cmd_op,
  input logic         mem_req,
  input logic         mem_ack,
  input logic [W-1:0] mem_src,
  input logic [W-1:0] mem_dst,
  input logic         busy,
  input logic         done,
  input logic         br_valid,
  input logic         br_taken,
  input logic [W-1:0] cnt_out
);
  localparam logic [W-1:0] D1 = W'(1);
  localparam logic [W-1:0] D2 = W'(2);
  localparam logic [W-1:0] M1 = {W{1'b1}};
  localparam logic [W-1:0] M2 = M1 - D1;

  logic idle_cmd;
  assign idle_cmd = !busy && !ld_en && cmd_valid;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_src) && $stable(mem_dst))); // R3

  AST_PTR_SAME_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> ((mem_src - $past(mem_src)) == (mem_dst - $past(mem_dst)))); // R3

  AST_PTR_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (((mem_src - $past(mem_src)) == D1) || ((mem_src - $past(mem_src)) == D2) ||
                              ((mem_src - $past(mem_src)) == M1) || ((mem_src - $past(mem_src)) == M2))); // R3

  AST_CNT_PER_ELEM: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (cnt_out == ($past(cnt_out) - D1))); // R4

  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && mem_req)); // R4

  AST_ZERO_START: assert property (@(posedge clk) disable iff (rst)
    (idle_cmd && (cmd_op <= OP_REPNE) && (cnt_out == '0)) |=> (done && !mem_req)); // R5

  AST_LOOP_STEP: assert property (@(posedge clk) disable iff (rst)
    (idle_cmd && (cmd_op == OP_LOOP)) |=>
      (br_valid && (cnt_out == ($past(cnt_out) - D1)) && (br_taken == (cnt_out != '0)))); // R7

  AST_ZERO_TEST: assert property (@(posedge clk) disable iff (rst)
    (idle_cmd && (cmd_op == OP_JCXZ)) |=> (br_valid && $stable(cnt_out) && (br_taken == (cnt_out == '0)))); // R8

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_ack) |=> ($stable(cnt_out) && !br_valid)); // R9
endmodule

bind strloop_ctrl strloop_ctrl_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ld_en     (ld_en),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_src   (mem_src),
  .mem_dst   (mem_dst),
  .busy      (busy),
  .done      (done),
  .br_valid  (br_valid),
  .br_taken  (br_taken),
  .cnt_out   (cnt_out)
);

// File: tb/strloop_ctrl_tb.sv
`timescale 1ns/1ps
module strloop_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [15:0] ld_cnt = '0, ld_src = '0, ld_dst = '0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic        cmd_dir = 1'b0, cmd_wide = 1'b0;
  logic        mem_req, mem_wide, busy, done, br_valid, br_taken;
  logic [15:0] mem_src, mem_dst, cnt_out, src_out, dst_out;
  logic        mem_ack = 1'b0, mem_zf = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit stall_ph = 0;
  logic [15:0] exp_src_q[$];
  logic [15:0] exp_dst_q[$];
  logic        exp_zf_q[$];
  logic [15:0] m_cnt = '0, m_src = '0, m_dst = '0;

  always #2 clk = ~clk;

  strloop_ctrl u_dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_cnt(ld_cnt), .ld_src(ld_src), .ld_dst(ld_dst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dir(cmd_dir), .cmd_wide(cmd_wide),
    .mem_req(mem_req), .mem_src(mem_src), .mem_dst(mem_dst), .mem_wide(mem_wide),
    .mem_ack(mem_ack), .mem_zf(mem_zf), .busy(busy), .done(done),
    .br_valid(br_valid), .br_taken(br_taken), .cnt_out(cnt_out), .src_out(src_out), .dst_out(dst_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor and responder: compares every request against the scoreboard queue
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (!rst && mem_req) begin
      if (exp_src_q.size() == 0) begin
        chk(1'b0, "R4 extra element", {mem_src, mem_dst}, 32'h0);
        mem_ack = 1'b1;
        mem_zf  = 1'b0;
      end else begin
        chk(mem_src == exp_src_q[0] && mem_dst == exp_dst_q[0], "R3 element pointers",
            {mem_src, mem_dst}, {exp_src_q[0], exp_dst_q[0]});
        if (!stall_ph) begin
          mem_ack = 1'b1;
          mem_zf  = exp_zf_q[0];
          void'(exp_src_q.pop_front());
          void'(exp_dst_q.pop_front());
          void'(exp_zf_q.pop_front());
        end
      end
      stall_ph = ~stall_ph;
    end
  end

  task automatic load(input logic [15:0] c, input logic [15:0] s, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_cnt = c; ld_src = s; ld_dst = d;
    @(negedge clk);
    ld_en = 1'b0;
    m_cnt = c; m_src = s; m_dst = d;
    chk(cnt_out == c && src_out == s && dst_out == d, "R2 load", {cnt_out, src_out}, {c, s});
  endtask

  // Driver: pushes expected elements, then issues the repeat command
  task automatic push_str(input logic [2:0] op, input bit dir, input bit wide, input int stop_at);
    logic [15:0] st;
    bit z;
    st = wide ? 16'd2 : 16'd1;
    for (int k = 0; m_cnt != 0; k++) begin
      z = (op == 3'd1) ? (k != stop_at) : (op == 3'd2) ? (k == stop_at) : k[0];
      exp_src_q.push_back(m_src);
      exp_dst_q.push_back(m_dst);
      exp_zf_q.push_back(z);
      m_src = dir ? m_src - st : m_src + st;
      m_dst = dir ? m_dst - st : m_dst + st;
      m_cnt = m_cnt - 16'd1;
      if (op != 3'd0 && k == stop_at) break;
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_dir = dir; cmd_wide = wide;
  endtask

  task automatic wait_done(input string tag);
    int w;
    w = 0;
    while (!done && w < 1000) begin
      @(negedge clk);
      w++;
    end
    chk(done, {tag, " done pulse"}, done, 1);
    chk(exp_src_q.size() == 0, {tag, " element count"}, exp_src_q.size(), 0);
    chk(cnt_out == m_cnt && src_out == m_src && dst_out == m_dst, {tag, " final state"},
        {cnt_out, src_out}, {m_cnt, m_src});
    @(negedge clk);
    chk(!done && !mem_req, "R4 done one cycle", {done, mem_req}, 0);
  endtask

  task automatic run_str(input logic [2:0] op, input bit dir, input bit wide, input int stop_at, input string tag);
    push_str(op, dir, wide, stop_at);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(tag);
  endtask

  task automatic loop_step(input string tag);
    logic [15:0] nc;
    nc = m_cnt - 16'd1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(br_valid && br_taken == (nc != 0), {tag, " branch"}, {br_valid, br_taken}, {1'b1, nc != 0});
    chk(cnt_out == nc && src_out == m_src && dst_out == m_dst, {tag, " count"}, cnt_out, nc);
    m_cnt = nc;
  endtask

  task automatic zero_test(input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(br_valid && br_taken == (m_cnt == 0), {tag, " branch"}, {br_valid, br_taken}, {1'b1, m_cnt == 0});
    chk(cnt_out == m_cnt, {tag, " count kept"}, cnt_out, m_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cnt_out == 0 && src_out == 0 && dst_out == 0, "R1 reset regs", {cnt_out, src_out}, 0);
    chk(!mem_req && !busy && !done && !br_valid, "R1 reset flags", {mem_req, busy, done, br_valid}, 0);

    // R4 byte move up, count 10
    load(16'd10, 16'h0100, 16'h0800);
    run_str(3'd0, 1'b0, 1'b0, 0, "R4 byte up");
    // R3 word move down with pointer wrap
    load(16'd4, 16'h0001, 16'h0010);
    run_str(3'd0, 1'b1, 1'b1, 0, "R3 word down");
    // R3 word up, byte down
    load(16'd3, 16'hFFFE, 16'h2000);
    run_str(3'd0, 1'b0, 1'b1, 0, "R3 word up");
    load(16'd5, 16'h3000, 16'h4000);
    run_str(3'd0, 1'b1, 1'b0, 0, "R3 byte down");
    // R5 zero count start, all three repeat codes
    for (int op = 0; op < 3; op++) begin
      load(16'd0, 16'h0500, 16'h0600);
      push_str(3'(op), 1'b0, 1'b0, 0);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(done && !mem_req, "R5 zero count done", {done, mem_req}, 2'b10);
      chk(cnt_out == 0 && src_out == 16'h0500, "R5 no change", src_out, 16'h0500);
    end
    // R6 compare variants
    load(16'd6, 16'h1000, 16'h1100);
    run_str(3'd1, 1'b0, 1'b0, 2, "R6 while equal early");
    load(16'd4, 16'h1000, 16'h1100);
    run_str(3'd1, 1'b0, 1'b1, 99, "R6 while equal full");
    load(16'd5, 16'h1200, 16'h1300);
    run_str(3'd2, 1'b1, 1'b0, 0, "R6 while not equal first");
    load(16'd5, 16'h1200, 16'h1300);
    run_str(3'd2, 1'b0, 1'b0, 3, "R6 while not equal late");

    // R9 and R2: load and loop step during a repeat are ignored
    load(16'd3, 16'h0100, 16'h0200);
    push_str(3'd0, 1'b0, 1'b0, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    ld_en = 1'b1; ld_cnt = 16'h7777; ld_src = 16'h7777; ld_dst = 16'h7777;
    @(negedge clk);
    ld_en = 1'b0;
    cmd_valid = 1'b1; cmd_op = 3'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!br_valid, "R9 no branch while busy", br_valid, 0);
    wait_done("R9 ignore while busy");

    // R7 loop step and R8 zero test
    load(16'd2, 16'h0AAA, 16'h0BBB);
    loop_step("R7 two to one");
    loop_step("R7 one to zero");
    zero_test("R8 zero taken");
    loop_step("R7 zero wraps");
    chk(cnt_out == 16'hFFFF, "R7 wrap value", cnt_out, 16'hFFFF);
    zero_test("R8 nonzero");

    // R7 65,536 passes from a zero count
    begin
      int passes;
      load(16'd0, 16'h0000, 16'h0000);
      passes = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd3;
      while (passes < 70000) begin
        @(negedge clk);
        if (br_valid) passes++;
        if (!br_taken) break;
      end
      cmd_valid = 1'b0;
      chk(passes == 65536, "R7 pass count", passes, 65536);
      chk(cnt_out == 0, "R7 end count", cnt_out, 0);
    end

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule